// File: doc/BRIEF.md
# Serial Byte Store-and-Forward Relay

The relay sits on a three-wire clocked serial link between a host microcontroller and a downstream receiver. The host frames each access with its chip enable and shifts data in on its own clock. The relay captures one complete byte, holds it, and only then replays it to the downstream device. It drives the downstream enable, clock and data lines itself, and the downstream clock is a fixed division of the relay's own system clock. The nominal system clock is 3.6 MHz and the default division is 8, which gives a downstream bit rate of about 450 kHz.

The replay takes time, so the relay reports a busy window. The window opens when the eighth host bit is accepted and closes when the downstream frame ends. The host must not touch the bus while it is open. The host-side open-drain data line is pulled low for the whole window, so the host can poll it or use its falling edge as a trigger. Any host clock edge that arrives while the window is open is discarded and sets a sticky error flag. All logic runs on the rising edge of the system clock, and the host lines are synchronised into that domain.

Top module: `byte_relay`

## Requirements
- R1: While reset is asserted and after it is released, dn_ce, dn_sck, dn_sdo, busy, err and host_sdo_pull are all 0.
- R2: Fewer than eight accepted host edges never start a downstream frame: dn_ce and busy stay 0.
- R3: When the host raises host_sck for the eighth accepted bit, busy and dn_ce are still 0 three clock cycles later and are both 1 four cycles later. This count includes two synchroniser stages, edge detection and the byte latch.
- R4: The latched byte goes out most significant bit first, one bit per downstream clock pulse. dn_sdo is stable while dn_sck is high, and the receiver samples it on the rising edge of dn_sck.
- R5: Each downstream bit lasts DIV system cycles. dn_sck is low for the first DIV/2 cycles and high for the last DIV/2 cycles, and each frame carries exactly 8 pulses.
- R6: dn_ce stays high for 8*DIV + DIV/2 cycles per frame: the eight bit periods plus a closing low-clock tail of DIV/2 cycles.
- R7: busy is high exactly while dn_ce is high, and host_sdo_pull (1 = pull the open-drain line low) equals busy.
- R8: A host clock rising edge sampled with host_ce high while busy is 1 is discarded. It sets err one cycle later and changes neither the byte being sent nor the bit count of the next byte. An edge that is evaluated in the last busy cycle is still discarded.
- R9: Taking host_ce low discards any partially received byte. The next byte then starts from bit 7 again.
- R10: err stays set until the next reset, even across later correct transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic acts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce | input | 1 | Host chip enable, active high |
| host_sck | input | 1 | Host serial clock; data sampled on its rising edge |
| host_sdi | input | 1 | Host serial data, MSB first |
| host_sdo_pull | output | 1 | Open-drain control for the host data line; 1 pulls low during the busy window |
| busy | output | 1 | High while a byte is being forwarded |
| err | output | 1 | Sticky flag for a host access attempted while busy |
| dn_ce | output | 1 | Downstream chip enable, high for one forwarded frame |
| dn_sck | output | 1 | Downstream shift clock, system clock divided by DIV |
| dn_sdo | output | 1 | Downstream serial data, MSB first |

## Verification
Two functions can act in the same cycle: the host receiver judging a fresh host clock edge, and the transmitter ending its frame and clearing busy. The bench provokes this by placing a stray host edge at each of several offsets around the end of a frame, with a reset between offsets. Each offset is judged twice. First, err must match the rule that an edge evaluated while busy still reads 1 is rejected. Second, the byte that follows must match that outcome: after a rejection it takes eight fresh bits, and after an acceptance the stray bit becomes its most significant bit.

// File: rtl/relay_pkg.sv
package relay_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_TAIL  = 2'd2
  } tx_state_t;

  // System cycles dn_ce stays high for one frame of w bits at divider div.
  function automatic int frame_cycles(input int w, input int div);
    return w * div + div / 2;
  endfunction

  // System cycles from the host edge request to the byte latch registering.
  function automatic int capture_latency(input int sync_stages);
    return sync_stages + 1;
  endfunction

endpackage

// File: rtl/relay_host_rx.sv
module relay_host_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_ce,
  input  logic         host_sck,
  input  logic         host_sdi,
  input  logic         busy,
  output logic         byte_done,
  output logic [W-1:0] byte_val,
  output logic         host_edge,
  output logic         err
);
  localparam int CW = $clog2(W);

  logic [1:0]   ce_sync;
  logic [2:0]   sck_sync;
  logic [1:0]   sdi_sync;
  logic [CW-1:0] bit_cnt;
  logic [W-2:0] partial;
  logic         accept;
  logic         reject;

  // Host lines are asynchronous to clk: two-stage synchronisers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sync  <= '0;
      sck_sync <= '0;
      sdi_sync <= '0;
    end else begin
      ce_sync  <= {ce_sync[0], host_ce};
      sck_sync <= {sck_sync[1:0], host_sck};
      sdi_sync <= {sdi_sync[0], host_sdi};
    end
  end

  assign host_edge = sck_sync[1] & ~sck_sync[2] & ce_sync[1];
  assign accept    = host_edge & ~busy;
  assign reject    = host_edge & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      partial   <= '0;
      byte_val  <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!ce_sync[1]) begin
        bit_cnt <= '0;
      end else if (accept) begin
        partial <= {partial[W-3:0], sdi_sync[1]};
        if (bit_cnt == CW'(W - 1)) begin
          bit_cnt   <= '0;
          byte_val  <= {partial, sdi_sync[1]};
          byte_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err <= 1'b0;
    else if (reject) err <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);  // R10

  AST_REJECT_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (host_edge && busy) |=> (err && !byte_done));  // R8

endmodule

// File: rtl/relay_fwd_tx.sv
module relay_fwd_tx
  import relay_pkg::*;
#(
  parameter int W   = 8,
  parameter int DIV = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] data,
  output logic         dn_ce,
  output logic         dn_sck,
  output logic         dn_sdo,
  output logic         done
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam int BW   = $clog2(W);

  tx_state_t     state;
  logic [CW-1:0] cyc;
  logic [BW-1:0] bit_idx;
  logic [W-1:0]  shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      cyc     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else begin
      unique case (state)
        TX_IDLE: begin
          if (start) begin
            state   <= TX_SHIFT;
            cyc     <= '0;
            bit_idx <= '0;
            shreg   <= data;
          end
        end
        TX_SHIFT: begin
          if (cyc == CW'(DIV - 1)) begin
            cyc   <= '0;
            shreg <= {shreg[W-2:0], 1'b0};
            if (bit_idx == BW'(W - 1)) state <= TX_TAIL;
            else                       bit_idx <= bit_idx + 1'b1;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        TX_TAIL: begin
          if (cyc == CW'(HALF - 1)) begin
            state <= TX_IDLE;
            cyc   <= '0;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign dn_ce  = (state != TX_IDLE);
  assign dn_sck = (state == TX_SHIFT) && (cyc >= CW'(HALF));
  assign dn_sdo = (state == TX_SHIFT) ? shreg[W-1] : 1'b0;
  assign done   = (state == TX_TAIL) && (cyc == CW'(HALF - 1));

  AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    dn_sck |-> dn_ce);  // R5

  AST_SDO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_sck && $past(dn_sck)) |-> $stable(dn_sdo));  // R4

endmodule

// File: rtl/byte_relay.sv
module byte_relay #(
  parameter int W   = 8,
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_ce,
  input  logic host_sck,
  input  logic host_sdi,
  output logic host_sdo_pull,
  output logic busy,
  output logic err,
  output logic dn_ce,
  output logic dn_sck,
  output logic dn_sdo
);
  localparam int FRAME = relay_pkg::frame_cycles(W, DIV);

  logic         byte_done;
  logic [W-1:0] byte_val;
  logic         host_edge;
  logic         tx_done;
  logic [15:0]  busy_len;

  relay_host_rx #(.W(W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ce   (host_ce),
    .host_sck  (host_sck),
    .host_sdi  (host_sdi),
    .busy      (busy),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .host_edge (host_edge),
    .err       (err)
  );

  relay_fwd_tx #(.W(W), .DIV(DIV)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (byte_done),
    .data   (byte_val),
    .dn_ce  (dn_ce),
    .dn_sck (dn_sck),
    .dn_sdo (dn_sdo),
    .done   (tx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (byte_done) busy <= 1'b1;
    else if (tx_done)   busy <= 1'b0;
  end

  assign host_sdo_pull = busy;

  // Length of the current busy window, kept for the frame-bound check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (busy && dn_ce));  // R3

  AST_CE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dn_ce |-> busy);  // R7

  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len < 16'(FRAME)));  // R6

  AST_IDLE_UNTIL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(byte_done));  // R2

endmodule

// File: tb/byte_relay_bench.sv
`timescale 1ns/1ps
module byte_relay_bench;
  localparam int W   = 8;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_ce = 1'b0, host_sck = 1'b0, host_sdi = 1'b0;
  logic host_sdo_pull, busy, err, dn_ce, dn_sck, dn_sdo;

  always #10 clk = ~clk;

  byte_relay #(.W(W), .DIV(DIV)) u_byte_relay (
    .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_sck(host_sck),
    .host_sdi(host_sdi), .host_sdo_pull(host_sdo_pull), .busy(busy),
    .err(err), .dn_ce(dn_ce), .dn_sck(dn_sck), .dn_sdo(dn_sdo)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  function automatic int exp_frame_len(input int div);
    return 8 * div + div / 2;
  endfunction
  function automatic int exp_high_cycles(input int div);
    return 8 * (div / 2);
  endfunction
  function automatic logic [7:0] exp_merged(input logic a, input logic [7:0] b);
    return {a, b[7:1]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Downstream receiver model: sample on dn_sck rising edge.
  logic [7:0] cap = '0, got_byte = '0;
  int nbits = 0, got_bits = 0, frames = 0;
  always @(posedge dn_sck) begin
    cap = {cap[6:0], dn_sdo};
    nbits++;
  end
  always @(negedge dn_ce) begin
    if (rst_n) begin
      got_byte = cap;
      got_bits = nbits;
      frames++;
    end
    nbits = 0;
  end
  always @(negedge rst_n) nbits = 0;

  // Frame timing monitor.
  int len = 0, hi = 0, lowrun = 0;
  logic pce = 1'b0, psck = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      len = 0; hi = 0; lowrun = 0; pce = 1'b0; psck = 1'b0;
    end else begin
      if (dn_ce) begin
        len++;
        if (dn_sck) hi++;
        if (dn_sck && !psck) begin
          chk(lowrun == DIV / 2, "R5 low time", lowrun, DIV / 2);
          lowrun = 0;
        end
        if (!dn_sck) lowrun++;
        chk(busy == 1'b1, "R7 busy during frame", busy, 1);
      end
      if (pce && !dn_ce) begin
        chk(len == exp_frame_len(DIV), "R6 frame length", len, exp_frame_len(DIV));
        chk(hi == exp_high_cycles(DIV), "R5 high cycles", hi, exp_high_cycles(DIV));
        len = 0; hi = 0; lowrun = 0;
      end
      if (!dn_ce && busy) chk(1'b0, "R7 busy outside frame", busy, 0);
      chk(host_sdo_pull == busy, "R7 pull mirrors busy", host_sdo_pull, busy);
      pce = dn_ce; psck = dn_sck;
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b, input int half);
    host_sdi = b;
    repeat (half) @(negedge clk);
    host_sck = 1'b1;
    repeat (half) @(negedge clk);
    host_sck = 1'b0;
  endtask

  // Sends n bits of v (v[n-1] first); the last bit must complete a byte.
  task automatic send_bits(input logic [7:0] v, input int n, input int half);
    while (busy) @(negedge clk);
    host_ce = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 1; i--) pulse_bit(v[i], half);
    host_sdi = v[0];
    repeat (half) @(negedge clk);
    host_sck = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && dn_ce == 1'b0, "R3 not yet busy", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1 && dn_ce == 1'b1, "R3 busy after latch", busy, 1);
    host_sck = 1'b0;
  endtask

  task automatic expect_frame(input logic [7:0] exp, input string req);
    chk(got_byte == exp, req, got_byte, exp);
    chk(got_bits == 8, "R5 pulse count", got_bits, 8);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; host_ce = 1'b0; host_sck = 1'b0; host_sdi = 1'b0;
    repeat (3) @(negedge clk);
    chk({dn_ce, dn_sck, dn_sdo, busy, err, host_sdo_pull} == 6'b0, "R1 in reset",
        {dn_ce, dn_sck, dn_sdo, busy, err, host_sdo_pull}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    logic [7:0] b;
    int half;
    void'($urandom(32'h5eed_1234));
    do_reset();
    chk({dn_ce, dn_sck, dn_sdo, busy, err, host_sdo_pull} == 6'b0, "R1 after release",
        {dn_ce, dn_sck, dn_sdo, busy, err, host_sdo_pull}, 0);

    // R2 / R9: seven edges, then drop enable, then a full byte.
    f0 = frames;
    host_ce = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 7; i++) pulse_bit(1'b1, 5);
    repeat (12) @(negedge clk);
    chk(dn_ce == 1'b0 && busy == 1'b0, "R2 seven bits no frame", dn_ce, 0);
    chk(frames == f0, "R2 no frame counted", frames, f0);
    host_ce = 1'b0;
    repeat (5) @(negedge clk);
    send_bits(8'h35, 8, 5);
    wait_idle();
    expect_frame(8'h35, "R9 partial discarded");
    host_ce = 1'b0;

    // Directed corner patterns, R4.
    send_bits(8'h00, 8, 4); wait_idle(); expect_frame(8'h00, "R4 all zero"); host_ce = 1'b0;
    send_bits(8'hFF, 8, 4); wait_idle(); expect_frame(8'hFF, "R4 all one");  host_ce = 1'b0;
    send_bits(8'h80, 8, 4); wait_idle(); expect_frame(8'h80, "R4 msb first"); host_ce = 1'b0;

    // Constrained random bytes and host rates.
    for (int k = 0; k < 20; k++) begin
      b = 8'($urandom);
      half = 3 + int'($urandom % 8);
      send_bits(b, 8, half);
      wait_idle();
      expect_frame(b, "R4 random byte");
      host_ce = 1'b0;
      repeat (int'($urandom % 6) + 2) @(negedge clk);
    end

    // R8 / R10: access while busy is ignored, err sticky.
    chk(err == 1'b0, "R8 err clear before", err, 0);
    send_bits(8'hA6, 8, 4);
    repeat (10) @(negedge clk);
    pulse_bit(1'b1, 4);
    repeat (2) @(negedge clk);
    chk(err == 1'b1, "R8 err set while busy", err, 1);
    wait_idle();
    expect_frame(8'hA6, "R8 frame unchanged");
    send_bits(8'h5C, 8, 4);
    wait_idle();
    expect_frame(8'h5C, "R8 next byte count intact");
    chk(err == 1'b1, "R10 err sticky", err, 1);
    host_ce = 1'b0;
    do_reset();
    chk(err == 1'b0, "R10 cleared by reset", err, 0);

    // Collision sweep: stray edge around the cycle busy falls.
    for (int k = 62; k <= 69; k++) begin
      logic rej;
      do_reset();
      send_bits(8'h3C, 8, 4);
      host_sdi = 1'b1;
      repeat (k) @(negedge clk);
      host_sck = 1'b1;
      repeat (4) @(negedge clk);
      host_sck = 1'b0;
      repeat (2) @(negedge clk);
      rej = (k <= 65);
      chk(err == rej, "R8 last busy cycle rejects", err, rej);
      wait_idle();
      expect_frame(8'h3C, "R8 collision frame");
      if (err) begin
        send_bits(8'h96, 8, 4); wait_idle(); expect_frame(8'h96, "R8 rejected edge");
      end else begin
        send_bits(8'h96 >> 1, 7, 4); wait_idle();
        expect_frame(exp_merged(1'b1, 8'h96), "R8 accepted edge");
      end
      host_ce = 1'b0;
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule